// File: doc/BRIEF.md
# Ethernet MAC Register Initialization Sequencer

This block stands in for host software during the bring-up of a tri-speed Ethernet MAC. After a `start` pulse it acts as a master on a simple memory-mapped register bus. It issues a fixed, ordered list of register writes that selects the external PHY and sets its control register. The same list disables the MAC datapath, sets the FIFO thresholds, loads the station address, frame length, inter-packet gap and pause quanta, and loads the command word. It then soft-resets the MAC and finally enables transmit and receive.

At three points the sequencer reads the command register back and keeps reading until the value it expects appears:
- after the disable write;
- after the soft reset, whose bit clears itself;
- after the final enable write.

Each of these polls is bounded by a cycle limit that is captured at start. If a poll runs past its limit, the block stops in a fault state and reports the index of the step that failed. The link rate and duplex bits of the command word come from input pins sampled at start, so one sequence serves every rate. A parameter chooses cut-through or store-and-forward FIFO operation.

Top module: `mac_cfg_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `bus_wr` and `bus_rd` are low and `fail_step` is 0.
- R2: A `start` pulse while the block is not busy produces exactly 19 writes, in this order:

  | # | Address | Data |
  |---|---------|------|
  | 0 | 0x0F | 0x0A |
  | 1 | 0x80 (PHY register 0) | 0x1140 |
  | 2 | 0x02 | C or 0x2000 |
  | 3 | 0x10 | depth−16 |
  | 4 | 0x11 | 3 |
  | 5 | 0x12 | 8 |
  | 6 | 0x13 | depth−16 |
  | 7 | 0x14 | 8 |
  | 8 | 0x15 | 8 |
  | 9 | 0x16 | S |
  | 10 | 0x17 | S |
  | 11 | 0x03 | 0x17231C00 |
  | 12 | 0x04 | 0x0000CB4A |
  | 13 | 0x05 | 1518 |
  | 14 | 0x18 | 12 |
  | 15 | 0x06 | 0xFFFF |
  | 16 | 0x02 | C |
  | 17 | 0x02 | C or 0x2000 |
  | 18 | 0x02 | C or 0x3 |

  Here depth is 2048 by default, C is the command word of R8, and S is the section-full value of R9.
- R3: While a strobe (`bus_wr` or `bus_rd`) is high and `bus_wait` is high, the address, the write data and the strobe are held. An access completes on the first rising edge with `bus_wait` low. `bus_wr` and `bus_rd` are never high together.
- R4: The first poll, after write 2, reads address 0x02 and compares only bits 1:0, which must both read 0. Whether the reset bit 13 has cleared does not affect this poll.
- R5: After write 17, reads of address 0x02 repeat until the value equals C exactly, with bit 13 cleared. Write 18 is issued only after that match.
- R6: After write 18, reads repeat until the value equals C or 0x3. `done` rises only on the cycle after that matching read completes. `done` then stays high with `busy` low.
- R7: If a poll's completed read does not match once `poll_limit` cycles have passed in that poll step, the block enters a fault state. In that state `error` is high, `fail_step` holds the step index (3, 19 or 21 for the three polls), and no strobes are issued. A new `start` clears the fault and runs the sequence again from the beginning.
- R8: C = 0x00800220, with bit 3 set by `link_gig`, bit 25 set by `link_10m` and bit 10 set by `link_half`. These three pins, and `poll_limit`, are sampled at `start`.
- R9: With parameter CUT_THROUGH = 1, the value S written to addresses 0x16 and 0x17 is 16. With CUT_THROUGH = 0 it is 0, which selects store-and-forward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin the sequence |
| link_gig | input | 1 | Gigabit rate select for the command word |
| link_10m | input | 1 | 10 Mb/s rate select for the command word |
| link_half | input | 1 | Half-duplex select for the command word |
| poll_limit | input | 16 | Cycle limit for each poll step |
| bus_addr | output | 8 | Register dword address |
| bus_wdata | output | 32 | Write data; holds the expected value during reads |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | 32 | Read data, valid when `bus_wait` is low |
| bus_wait | input | 1 | Slave stall |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence finished |
| error | output | 1 | Poll timed out |
| fail_step | output | 5 | Index of the step that timed out |

## Verification
A wrong step counter or a wrong value table shows up at once as a misplaced or wrong entry in the captured write log, on the same cycle the write completes. A faulty poll compare shows up in one of two ways. It either lets a write through before the slave has cleared its reset bit, which the log shows at the position of the enable write. Or it never matches, so `error` rises about `poll_limit` cycles into the poll with a `fail_step` that names that poll. Broken hold logic changes the address or data while the slave is stalling, and the stub sees this on the next edge.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  parameter int unsigned MCS_AW     = 8;
  parameter int unsigned MCS_DW     = 32;
  parameter int unsigned MCS_NSTEPS = 22;
  parameter int unsigned MCS_SW     = $clog2(MCS_NSTEPS);

  // register dword addresses decoded by the MAC
  localparam logic [MCS_AW-1:0] A_CMD    = 8'h02;
  localparam logic [MCS_AW-1:0] A_STA_LO = 8'h03;
  localparam logic [MCS_AW-1:0] A_STA_HI = 8'h04;
  localparam logic [MCS_AW-1:0] A_FRMLEN = 8'h05;
  localparam logic [MCS_AW-1:0] A_PAUSE  = 8'h06;
  localparam logic [MCS_AW-1:0] A_PHYSEL = 8'h0F;
  localparam logic [MCS_AW-1:0] A_TX_SE  = 8'h10;
  localparam logic [MCS_AW-1:0] A_TX_AF  = 8'h11;
  localparam logic [MCS_AW-1:0] A_TX_AE  = 8'h12;
  localparam logic [MCS_AW-1:0] A_RX_SE  = 8'h13;
  localparam logic [MCS_AW-1:0] A_RX_AF  = 8'h14;
  localparam logic [MCS_AW-1:0] A_RX_AE  = 8'h15;
  localparam logic [MCS_AW-1:0] A_TX_SF  = 8'h16;
  localparam logic [MCS_AW-1:0] A_RX_SF  = 8'h17;
  localparam logic [MCS_AW-1:0] A_IPG    = 8'h18;
  localparam logic [MCS_AW-1:0] A_MDIO0  = 8'h80;

  // command word fields
  localparam logic [MCS_DW-1:0] CMD_BASE  = 32'h0080_0220;
  localparam logic [MCS_DW-1:0] CMD_SWRST = 32'h0000_2000;
  localparam logic [MCS_DW-1:0] CMD_ENA   = 32'h0000_0003;
  localparam int unsigned BIT_GIG  = 3;
  localparam int unsigned BIT_HALF = 10;
  localparam int unsigned BIT_TEN  = 25;

  typedef enum logic {OP_WRITE, OP_POLL} op_e;
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE, S_FAULT} state_e;

  typedef struct packed {
    op_e               op;
    logic [MCS_AW-1:0] addr;
    logic [MCS_DW-1:0] data;   // write value, or expected read value
    logic [MCS_DW-1:0] mask;   // bits compared on a poll
  } step_t;
endpackage

// File: rtl/mcs_step_rom.sv
module mcs_step_rom
  import mcs_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 2048,
  parameter bit          CUT_THROUGH = 1'b1,
  parameter logic [MCS_DW-1:0] PHY_SEL   = 32'h0000_000A,
  parameter logic [MCS_DW-1:0] PHY_REG0  = 32'h0000_1140
) (
  input  logic [MCS_SW-1:0] step,
  input  logic [MCS_DW-1:0] cmd_base,
  output step_t             cur
);
  localparam logic [MCS_DW-1:0] SECT_EMPTY = MCS_DW'(FIFO_DEPTH - 16);

  logic [MCS_DW-1:0] sect_full;

  generate
    if (CUT_THROUGH) begin : g_cut
      assign sect_full = 32'd16;
    end else begin : g_saf
      assign sect_full = 32'd0;
    end
  endgenerate

  always_comb begin
    cur.op   = OP_WRITE;
    cur.addr = A_CMD;
    cur.data = '0;
    cur.mask = '1;
    case (int'(step))
      0:  begin cur.addr = A_PHYSEL; cur.data = PHY_SEL;               end
      1:  begin cur.addr = A_MDIO0;  cur.data = PHY_REG0;              end
      2:  begin cur.addr = A_CMD;    cur.data = cmd_base | CMD_SWRST;  end
      3:  begin cur.op = OP_POLL; cur.addr = A_CMD; cur.mask = CMD_ENA; end
      4:  begin cur.addr = A_TX_SE;  cur.data = SECT_EMPTY;            end
      5:  begin cur.addr = A_TX_AF;  cur.data = 32'd3;                 end
      6:  begin cur.addr = A_TX_AE;  cur.data = 32'd8;                 end
      7:  begin cur.addr = A_RX_SE;  cur.data = SECT_EMPTY;            end
      8:  begin cur.addr = A_RX_AF;  cur.data = 32'd8;                 end
      9:  begin cur.addr = A_RX_AE;  cur.data = 32'd8;                 end
      10: begin cur.addr = A_TX_SF;  cur.data = sect_full;             end
      11: begin cur.addr = A_RX_SF;  cur.data = sect_full;             end
      12: begin cur.addr = A_STA_LO; cur.data = 32'h1723_1C00;         end
      13: begin cur.addr = A_STA_HI; cur.data = 32'h0000_CB4A;         end
      14: begin cur.addr = A_FRMLEN; cur.data = 32'd1518;              end
      15: begin cur.addr = A_IPG;    cur.data = 32'd12;                end
      16: begin cur.addr = A_PAUSE;  cur.data = 32'h0000_FFFF;         end
      17: begin cur.addr = A_CMD;    cur.data = cmd_base;              end
      18: begin cur.addr = A_CMD;    cur.data = cmd_base | CMD_SWRST;  end
      19: begin cur.op = OP_POLL; cur.addr = A_CMD; cur.data = cmd_base; end
      20: begin cur.addr = A_CMD;    cur.data = cmd_base | CMD_ENA;    end
      21: begin cur.op = OP_POLL; cur.addr = A_CMD; cur.data = cmd_base | CMD_ENA; end
      default: begin cur.addr = A_CMD; cur.data = cmd_base; end
    endcase
  end
endmodule

// File: rtl/mcs_poll_timer.sv
module mcs_poll_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr || (en && (cnt_q != CNT_MAX));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q >= limit);

  // once expired inside a poll step, stays expired until cleared
  p_expired_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && expired) |=> expired);
endmodule

// File: rtl/mac_cfg_sequencer.sv
module mac_cfg_sequencer
  import mcs_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 2048,
  parameter bit          CUT_THROUGH = 1'b1,
  parameter int unsigned CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              link_gig,
  input  logic              link_10m,
  input  logic              link_half,
  input  logic [CNT_W-1:0]  poll_limit,
  output logic [MCS_AW-1:0] bus_addr,
  output logic [MCS_DW-1:0] bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  input  logic [MCS_DW-1:0] bus_rdata,
  input  logic              bus_wait,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [MCS_SW-1:0] fail_step
);
  localparam logic [MCS_SW-1:0] LAST_STEP = MCS_SW'(MCS_NSTEPS - 1);

  // asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  state_e            state_q, state_d;
  logic [MCS_SW-1:0] step_q, step_d, fail_q, fail_d;
  logic [MCS_DW-1:0] cmd_q, cmd_in;
  logic [CNT_W-1:0]  lim_q;
  logic              cfg_load, advance, acc_done, rd_match, expired, tmr_clr;
  step_t             cur;

  mcs_step_rom #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .CUT_THROUGH(CUT_THROUGH)
  ) u_rom (
    .step    (step_q),
    .cmd_base(cmd_q),
    .cur     (cur)
  );

  mcs_poll_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (tmr_clr),
    .en     ((state_q == S_RUN) && (cur.op == OP_POLL)),
    .limit  (lim_q),
    .expired(expired)
  );

  always_comb begin
    cmd_in           = CMD_BASE;
    cmd_in[BIT_GIG]  = link_gig;
    cmd_in[BIT_HALF] = link_half;
    cmd_in[BIT_TEN]  = link_10m;
  end

  assign acc_done = (bus_wr || bus_rd) && !bus_wait;
  assign rd_match = ((bus_rdata ^ cur.data) & cur.mask) == '0;

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    fail_d   = fail_q;
    cfg_load = 1'b0;
    advance  = 1'b0;
    case (state_q)
      S_RUN: begin
        if (acc_done) begin
          if (cur.op == OP_WRITE || rd_match) begin
            advance = 1'b1;
            if (step_q == LAST_STEP) state_d = S_DONE;
            else                     step_d  = step_q + 1'b1;
          end else if (expired) begin
            state_d = S_FAULT;
            fail_d  = step_q;
          end
        end
      end
      default: begin
        if (start) begin
          state_d  = S_RUN;
          step_d   = '0;
          fail_d   = '0;
          cfg_load = 1'b1;
        end
      end
    endcase
  end

  assign tmr_clr = (state_q != S_RUN) || advance;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      fail_q  <= '0;
      cmd_q   <= CMD_BASE;
      lim_q   <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      fail_q  <= fail_d;
      if (cfg_load) begin
        cmd_q <= cmd_in;
        lim_q <= poll_limit;
      end
    end
  end

  assign bus_wr    = (state_q == S_RUN) && (cur.op == OP_WRITE);
  assign bus_rd    = (state_q == S_RUN) && (cur.op == OP_POLL);
  assign bus_addr  = cur.addr;
  assign bus_wdata = cur.data;
  assign busy      = (state_q == S_RUN);
  assign done      = (state_q == S_DONE);
  assign error     = (state_q == S_FAULT);
  assign fail_step = fail_q;

  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_wr && bus_rd));

  p_hold_on_wait_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((bus_wr || bus_rd) && bus_wait) |=>
      ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_wr) && $stable(bus_rd)));

  p_done_after_match_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(done) |-> ($past(bus_rd) && !$past(bus_wait) && ($past(bus_rdata) == $past(bus_wdata))));

  p_done_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> (!busy && !error));

  p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    error |-> (!bus_wr && !bus_rd));

  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (error && !start) |=> error);
endmodule

// File: tb/tb_mac_cfg_sequencer.sv
module tb_reg_stub (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  input  logic        wr,
  input  logic        rd,
  input  logic        stuck,
  input  logic        fast,
  output logic [31:0] rdata,
  output logic        wait_o
);
  logic [31:0] cmd_q;
  logic [7:0]  s_addr, h_addr;
  logic [31:0] s_wdata, h_wdata;
  logic        s_wr, s_rd, s_wait, h_wr, h_rd, h_wait;
  int          rcnt, wcnt, clr_wcnt, hold_err;
  logic [7:0]  log_a [0:63];
  logic [31:0] log_d [0:63];

  assign rdata = (addr == 8'h02) ? cmd_q : 32'h0;

  always @(negedge clk) begin
    logic w;
    w = rst_n && ($urandom_range(0, 3) == 0);
    wait_o  <= w;
    s_wait  <= w;
    s_addr  <= addr;
    s_wdata <= wdata;
    s_wr    <= wr;
    s_rd    <= rd;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 32'h3; rcnt <= 0; wcnt <= 0; clr_wcnt <= -1; hold_err <= 0;
      h_wr <= 1'b0; h_rd <= 1'b0; h_wait <= 1'b0; h_addr <= '0; h_wdata <= '0;
    end else begin
      if ((h_wr || h_rd) && h_wait &&
          (s_addr != h_addr || s_wdata != h_wdata || s_wr != h_wr || s_rd != h_rd))
        hold_err <= hold_err + 1;
      h_wr <= s_wr; h_rd <= s_rd; h_wait <= s_wait; h_addr <= s_addr; h_wdata <= s_wdata;
      if (s_wr && !s_wait) begin
        log_a[wcnt] <= s_addr;
        log_d[wcnt] <= s_wdata;
        wcnt <= wcnt + 1;
        if (s_addr == 8'h02) begin
          if (s_wdata[13] && fast) begin
            cmd_q <= s_wdata & ~32'h2000;
            clr_wcnt <= wcnt + 1;
          end else cmd_q <= s_wdata;
          if (s_wdata[13] && !fast) rcnt <= $urandom_range(2, 20);
        end
      end else if (rcnt > 0) begin
        rcnt <= rcnt - 1;
        if (rcnt == 1 && !stuck) begin
          cmd_q[13] <= 1'b0;
          clr_wcnt  <= wcnt;
        end
      end
    end
  end
endmodule

module tb_mac_cfg_sequencer;
  logic        clk = 1'b0;
  logic        rst_n, start, gig, ten, half, stuck, fast;
  logic [15:0] limit;
  logic [7:0]  a0, a1;
  logic [31:0] wd0, wd1, rd0, rd1;
  logic        wr0, rd0s, wt0, wr1, rd1s, wt1;
  logic        busy0, done0, err0, busy1, done1, err1;
  logic [4:0]  fs0, fs1;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mac_cfg_sequencer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .link_gig(gig), .link_10m(ten),
    .link_half(half), .poll_limit(limit), .bus_addr(a0), .bus_wdata(wd0),
    .bus_wr(wr0), .bus_rd(rd0s), .bus_rdata(rd0), .bus_wait(wt0),
    .busy(busy0), .done(done0), .error(err0), .fail_step(fs0));

  tb_reg_stub stub (
    .clk(clk), .rst_n(rst_n), .addr(a0), .wdata(wd0), .wr(wr0), .rd(rd0s),
    .stuck(stuck), .fast(fast), .rdata(rd0), .wait_o(wt0));

  mac_cfg_sequencer #(.CUT_THROUGH(1'b0)) dut_sf (
    .clk(clk), .rst_n(rst_n), .start(start), .link_gig(gig), .link_10m(ten),
    .link_half(half), .poll_limit(limit), .bus_addr(a1), .bus_wdata(wd1),
    .bus_wr(wr1), .bus_rd(rd1s), .bus_rdata(rd1), .bus_wait(wt1),
    .busy(busy1), .done(done1), .error(err1), .fail_step(fs1));

  tb_reg_stub stub_sf (
    .clk(clk), .rst_n(rst_n), .addr(a1), .wdata(wd1), .wr(wr1), .rd(rd1s),
    .stuck(1'b0), .fast(1'b0), .rdata(rd1), .wait_o(wt1));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cmd_word(input bit g, input bit t, input bit h);
    cmd_word = 32'h0080_0220 | ({31'd0, g} << 3) | ({31'd0, h} << 10) | ({31'd0, t} << 25);
  endfunction

  function automatic logic [39:0] exp_w(input int i, input bit g, input bit t, input bit h, input bit ct);
    logic [31:0] c, sf;
    c  = cmd_word(g, t, h);
    sf = ct ? 32'd16 : 32'd0;
    case (i)
      0: exp_w = {8'h0F, 32'h0A};        1: exp_w = {8'h80, 32'h1140};
      2: exp_w = {8'h02, c | 32'h2000};  3: exp_w = {8'h10, 32'd2032};
      4: exp_w = {8'h11, 32'd3};         5: exp_w = {8'h12, 32'd8};
      6: exp_w = {8'h13, 32'd2032};      7: exp_w = {8'h14, 32'd8};
      8: exp_w = {8'h15, 32'd8};         9: exp_w = {8'h16, sf};
      10: exp_w = {8'h17, sf};           11: exp_w = {8'h03, 32'h1723_1C00};
      12: exp_w = {8'h04, 32'h0000_CB4A}; 13: exp_w = {8'h05, 32'd1518};
      14: exp_w = {8'h18, 32'd12};       15: exp_w = {8'h06, 32'h0000_FFFF};
      16: exp_w = {8'h02, c};            17: exp_w = {8'h02, c | 32'h2000};
      default: exp_w = {8'h02, c | 32'h3};
    endcase
  endfunction

  // R2 / R8: ordered write log of the main stub from entry base
  task automatic check_main_log(input int base, input string req);
    chk(stub.wcnt - base == 19, {req, " write count"}, 64'(stub.wcnt - base), 64'd19);
    for (int i = 0; i < 19; i++)
      chk({stub.log_a[base+i], stub.log_d[base+i]} == exp_w(i, gig, ten, half, 1'b1),
          req, {24'd0, stub.log_a[base+i], stub.log_d[base+i]},
          {24'd0, exp_w(i, gig, ten, half, 1'b1)});
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if (done0 || err0) break;
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int n;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; start = 1'b0; gig = 1'b0; ten = 1'b0; half = 1'b0;
    stuck = 1'b0; fast = 1'b0; limit = 16'd300;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy0 && !done0 && !err0 && !wr0 && !rd0s && fs0 == 0, "R1 reset outputs",
        {59'd0, busy0, done0, err0, wr0, rd0s}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy0 && !done0 && !err0 && !wr0 && !rd0s, "R1 idle after release",
        {59'd0, busy0, done0, err0, wr0, rd0s}, 64'd0);

    // directed: 100 Mb/s full duplex, random reset-clear delay
    pulse_start();
    chk(busy0 == 1'b1, "R2 busy after start", 64'(busy0), 64'd1);
    wait_end();
    check_main_log(0, "R2 ordered writes");
    chk(done0 && !busy0 && !err0, "R6 done held", {61'd0, done0, busy0, err0}, 64'h4);
    chk(stub.cmd_q == 32'h0080_0223, "R6 final command readback", 64'(stub.cmd_q), 64'h0080_0223);
    chk(stub.clr_wcnt == 18, "R5 enable write only after reset bit cleared",
        64'(stub.clr_wcnt), 64'd18);
    chk(stub.hold_err == 0, "R3 hold while wait", 64'(stub.hold_err), 64'd0);
    for (int k = 0; k < 3000 && !done1; k++) @(negedge clk);
    chk(done1 == 1'b1, "R9 store-and-forward instance done", 64'(done1), 64'd1);
    chk(stub_sf.log_d[9] == 32'd0 && stub_sf.log_d[10] == 32'd0, "R9 section-full zero",
        {stub_sf.log_d[9], stub_sf.log_d[10]}, 64'd0);
    chk(stub.log_d[9] == 32'd16 && stub.log_d[10] == 32'd16, "R9 section-full sixteen",
        {stub.log_d[9], stub.log_d[10]}, {32'd16, 32'd16});

    // directed: reset bit clears at once, first poll must pass on enable bits only
    do_reset();
    fast = 1'b1; gig = 1'b1;
    pulse_start();
    wait_end();
    chk(done0 && !err0, "R4 masked first poll", {62'd0, done0, err0}, 64'h2);
    check_main_log(0, "R8 gigabit command word");
    fast = 1'b0;

    // constrained random: link bits and poll limit
    for (int r = 0; r < 4; r++) begin
      do_reset();
      gig = 1'($urandom); ten = 1'($urandom); half = 1'($urandom);
      limit = 16'($urandom_range(100, 400));
      pulse_start();
      gig = ~gig; ten = ~ten; half = ~half; limit = 16'd0;  // changes after start are not sampled
      wait_end();
      gig = ~gig; ten = ~ten; half = ~half;
      chk(done0 && !err0, "R8 random run done", {62'd0, done0, err0}, 64'h2);
      check_main_log(0, "R8 sampled link bits");
      chk(stub.hold_err == 0, "R3 hold random run", 64'(stub.hold_err), 64'd0);
    end

    // timeout: reset bit never clears
    do_reset();
    gig = 1'b0; ten = 1'b0; half = 1'b0; limit = 16'd60; stuck = 1'b1;
    pulse_start();
    wait_end();
    chk(err0 && !done0 && !busy0, "R7 fault state", {61'd0, err0, done0, busy0}, 64'h4);
    chk(fs0 == 5'd19, "R7 failing step index", 64'(fs0), 64'd19);
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (wr0 || rd0s) n++;
    end
    chk(n == 0 && err0, "R7 no strobes in fault", 64'(n), 64'd0);
    stuck = 1'b0;
    n = stub.wcnt;
    pulse_start();
    chk(!err0 && fs0 == 0, "R7 start clears fault", {58'd0, err0, fs0}, 64'd0);
    wait_end();
    chk(done0 && !err0, "R7 restart completes", {62'd0, done0, err0}, 64'h2);
    check_main_log(n, "R7 restart ordered writes");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule